// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block models the keyboard end of a serial keyboard link. Key events arrive from the host side as an 8-bit scancode with a strobe. The low seven bits select an entry of a fixed 128-entry translation ROM. The top bit marks a key release and is carried unchanged onto the translated code. Each translated code is appended to a receive queue. The reader drains that queue one byte per read strobe, and a data-available flag tells it when there is something to take.

The host can also send command bytes to the keyboard. A reset command and two layout-query commands each discard everything in the queue. They then load a fixed two-byte identification answer, so that the answer is the next thing the reader sees. Every other command byte leaves the queue alone. When a command and a key event arrive in the same cycle, the answer is queued first and the key code follows it. The queue depth, the command codes and the answer bytes are all parameters.

Top module: `kbd_cmd_responder`

## Requirements
- R1: On a cycle with `key_valid` high, the code ROM[`key_scan[6:0]`] OR (`key_scan[7]` << 7) is appended to the queue. Some sample entries: index 1 gives 0x1D, index 14 gives 0x2B and index 127 gives 0x43.
- R2: ROM indices with no key assigned translate to 0x00. Examples are 84, 85, 89 to 95 and 120 to 124. With the release bit set, such an index queues 0x80.
- R3: Command byte 0x01 empties the queue. After that the queue holds exactly 0xFF then 0x04.
- R4: Command bytes 0x07 and 0x0F empty the queue. After that the queue holds exactly 0xFE then 0x13.
- R5: Every other command byte is ignored: the queue contents and the order of reads are unchanged.
- R6: If a recognised command and a key event occur in the same cycle, the queue afterwards holds the two answer bytes followed by the translated key code.
- R7: The queue is first-in first-out and holds 256 bytes. A key event that arrives while the queue is full is dropped, even if a read happens in the same cycle.
- R8: While the queue is empty, `rd_avail` is low and `rd_data` reads 0x00. A read strobe while the queue is empty has no effect.
- R9: After reset the queue is empty.
- R10: A key push and a read in the same cycle on a queue that is neither empty nor full both take effect.
- R11: `rd_data` always shows the oldest queued byte, with no read latency. A byte queued at a clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key event strobe |
| key_scan | input | 8 | Scancode: bit 7 is release, bits 6:0 are the ROM index |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| rd_en | input | 1 | Pop the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte, or 0x00 when empty |
| rd_avail | output | 1 | Queue holds at least one byte |

## Verification
The bench builds the block with its default parameters: a 256-entry queue and the standard command and answer codes. With the full depth, the queue can be filled with a few hundred back-to-back key events. That makes the drop-on-full rule, and the drop that still happens when a read coincides with a full queue, reachable both in a directed run and during a write-heavy random phase. The default command codes let random command bytes hit the reset, both layout queries and ignored values, including cycles where they coincide with key events and reads.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
   typedef logic [7:0] kbyte_t;

   typedef enum logic [1:0] {
      CMD_IGNORE = 2'd0,
      CMD_RESET  = 2'd1,
      CMD_LAYOUT = 2'd2
   } cmd_kind_e;

   function automatic kbyte_t with_release(kbyte_t code, logic rel);
      return code | {rel, 7'b0};
   endfunction
endpackage

// File: rtl/kbd_scan_xlate.sv
module kbd_scan_xlate
   import kbd_resp_pkg::*;
#(
   parameter int SCAN_W = 8
) (
   input  logic [SCAN_W-1:0] scan,
   output kbyte_t            code
);
   localparam int IDX_W = SCAN_W - 1;

   if (SCAN_W != 8) begin : g_bad_width
      $error("kbd_scan_xlate: SCAN_W must be 8");
   end

   logic [IDX_W-1:0] idx;
   kbyte_t           base;

   assign idx = scan[IDX_W-1:0];

   always_comb begin
      case (idx) inside
         7'd0:          base = 8'd127;
         [7'd1:7'd13]:  base = 8'(idx) + 8'd28;
         7'd14:         base = 8'd43;
         [7'd15:7'd27]: base = 8'(idx) + 8'd38;
         7'd28:         base = 8'd89;
         [7'd29:7'd40]: base = 8'(idx) + 8'd47;
         7'd41:         base = 8'd42;
         7'd42:         base = 8'd99;
         7'd43:         base = 8'd88;
         [7'd44:7'd54]: base = 8'(idx) + 8'd56;
         7'd55:         base = 8'd47;
         7'd56:         base = 8'd19;
         7'd57:         base = 8'd121;
         7'd58:         base = 8'd119;
         7'd59:         base = 8'd5;
         7'd60:         base = 8'd6;
         7'd61:         base = 8'd8;
         7'd62:         base = 8'd10;
         7'd63:         base = 8'd12;
         7'd64:         base = 8'd14;
         7'd65:         base = 8'd16;
         7'd66:         base = 8'd17;
         7'd67:         base = 8'd18;
         7'd68:         base = 8'd7;
         7'd69:         base = 8'd98;
         7'd70:         base = 8'd23;
         [7'd71:7'd74]: base = 8'(idx) - 8'd3;
         [7'd75:7'd77]: base = 8'(idx) + 8'd16;
         7'd78:         base = 8'd125;
         [7'd79:7'd81]: base = 8'(idx) + 8'd33;
         7'd82:         base = 8'd94;
         7'd83:         base = 8'd50;
         7'd86:         base = 8'd124;
         7'd87:         base = 8'd9;
         7'd88:         base = 8'd11;
         7'd96:         base = 8'd90;
         7'd98:         base = 8'd46;
         7'd99:         base = 8'd22;
         7'd100:        base = 8'd13;
         7'd101:        base = 8'd111;
         7'd102:        base = 8'd52;
         7'd103:        base = 8'd20;
         7'd104:        base = 8'd96;
         7'd105:        base = 8'd24;
         7'd106:        base = 8'd28;
         7'd107:        base = 8'd74;
         7'd108:        base = 8'd27;
         7'd109:        base = 8'd123;
         7'd110:        base = 8'd44;
         7'd111:        base = 8'd66;
         7'd113:        base = 8'd45;
         7'd114:        base = 8'd2;
         7'd115:        base = 8'd4;
         7'd116:        base = 8'd48;
         7'd119:        base = 8'd21;
         7'd125:        base = 8'd120;
         7'd126:        base = 8'd122;
         7'd127:        base = 8'd67;
         default:       base = 8'd0;   // R2: unassigned entries
      endcase
   end

   assign code = with_release(base, scan[SCAN_W-1]);   // R1
endmodule

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
   import kbd_resp_pkg::*;
#(
   parameter kbyte_t RESET_CMD  = 8'h01,
   parameter kbyte_t LAYOUT_CMD0 = 8'h07,
   parameter kbyte_t LAYOUT_CMD1 = 8'h0F,
   parameter kbyte_t RESET_ANS0 = 8'hFF,
   parameter kbyte_t RESET_ANS1 = 8'h04,
   parameter kbyte_t LAYOUT_ANS0 = 8'hFE,
   parameter kbyte_t LAYOUT_ANS1 = 8'h13
) (
   input  logic   cmd_valid,
   input  kbyte_t cmd_byte,
   output logic   flush,
   output kbyte_t ans0,
   output kbyte_t ans1
);
   if (RESET_CMD == LAYOUT_CMD0 || RESET_CMD == LAYOUT_CMD1) begin : g_bad_codes
      $error("kbd_cmd_decode: reset and layout command codes overlap");
   end

   cmd_kind_e kind;

   always_comb begin
      kind = CMD_IGNORE;                                   // R5
      if (cmd_valid) begin
         if (cmd_byte == RESET_CMD)                              kind = CMD_RESET;   // R3
         else if (cmd_byte == LAYOUT_CMD0 || cmd_byte == LAYOUT_CMD1) kind = CMD_LAYOUT; // R4
      end
   end

   always_comb begin
      unique case (kind)
         CMD_RESET:  begin ans0 = RESET_ANS0;  ans1 = RESET_ANS1;  end
         CMD_LAYOUT: begin ans0 = LAYOUT_ANS0; ans1 = LAYOUT_ANS1; end
         default:    begin ans0 = '0;          ans1 = '0;          end
      endcase
   end

   assign flush = (kind != CMD_IGNORE);
endmodule

// File: rtl/kbd_resp_fifo.sv
module kbd_resp_fifo
   import kbd_resp_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   flush,
   input  kbyte_t flush_b0,
   input  kbyte_t flush_b1,
   input  logic   push,
   input  kbyte_t push_data,
   input  logic   pop,
   output kbyte_t head,
   output logic   avail
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("kbd_resp_fifo: DEPTH must be a power of two, at least 4");
   end

   kbyte_t        mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign push_ok = push && (count != FULL_CNT);   // R7: dropped when full
   assign pop_ok  = pop && (count != '0);          // R8

   always_ff @(posedge clk) begin
      if (flush) begin
         mem[0] <= flush_b0;
         mem[1] <= flush_b1;
         if (push) mem[2] <= push_data;            // R6
      end else if (push_ok) begin
         mem[wptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         rptr  <= '0;
         wptr  <= push ? AW'(3) : AW'(2);
         count <= push ? CW'(3) : CW'(2);
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         count <= count + CW'(push_ok) - CW'(pop_ok);   // R10
      end
   end

   assign avail = (count != '0);
   assign head  = avail ? mem[rptr] : '0;          // R8, R11

   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   a_r3_flush_refill: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == CW'(2) || count == CW'(3)));

   a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL_CNT && push && !pop && !flush) |=> (count == FULL_CNT));

   a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push && !flush) |=> (count == '0 && !avail));

   a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0 && count != FULL_CNT && push && pop && !flush) |=> $stable(count));
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
   import kbd_resp_pkg::*;
#(
   parameter int     DEPTH       = 256,
   parameter kbyte_t RESET_CMD   = 8'h01,
   parameter kbyte_t LAYOUT_CMD0 = 8'h07,
   parameter kbyte_t LAYOUT_CMD1 = 8'h0F,
   parameter kbyte_t RESET_ANS0  = 8'hFF,
   parameter kbyte_t RESET_ANS1  = 8'h04,
   parameter kbyte_t LAYOUT_ANS0 = 8'hFE,
   parameter kbyte_t LAYOUT_ANS1 = 8'h13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_valid,
   input  logic [7:0] key_scan,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       rd_avail
);
   kbyte_t key_code, ans0, ans1;
   logic   flush;

   kbd_scan_xlate #(.SCAN_W(8)) xlate_i (
      .scan (key_scan),
      .code (key_code)
   );

   kbd_cmd_decode #(
      .RESET_CMD  (RESET_CMD),
      .LAYOUT_CMD0(LAYOUT_CMD0),
      .LAYOUT_CMD1(LAYOUT_CMD1),
      .RESET_ANS0 (RESET_ANS0),
      .RESET_ANS1 (RESET_ANS1),
      .LAYOUT_ANS0(LAYOUT_ANS0),
      .LAYOUT_ANS1(LAYOUT_ANS1)
   ) decode_i (
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .flush     (flush),
      .ans0      (ans0),
      .ans1      (ans1)
   );

   kbd_resp_fifo #(.DEPTH(DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .flush_b0  (ans0),
      .flush_b1  (ans1),
      .push      (key_valid),
      .push_data (key_code),
      .pop       (rd_en),
      .head      (rd_data),
      .avail     (rd_avail)
   );

   a_r3_answer_head: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte == RESET_CMD) |=> (rd_avail && rd_data == RESET_ANS0));

   a_r4_answer_head: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_byte == LAYOUT_CMD0 || cmd_byte == LAYOUT_CMD1))
      |=> (rd_avail && rd_data == LAYOUT_ANS0));

   a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_avail |-> (rd_data == 8'h00));
endmodule

// File: tb/kbd_cmd_responder_tb_top.sv
module kbd_cmd_responder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_valid = 1'b0;
   logic [7:0] key_scan = '0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_avail;

   int total = 0;
   int bad   = 0;
   logic [7:0] mq[$];

   always #5 clk = ~clk;

   kbd_cmd_responder dut_i (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_scan(key_scan),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .rd_en(rd_en),
      .rd_data(rd_data), .rd_avail(rd_avail)
   );

   function automatic logic [7:0] ref_code(logic [7:0] s);
      int i = int'(s[6:0]);
      int v = 0;
      if (i >= 1 && i <= 13) v = i + 28;
      else if (i >= 15 && i <= 27) v = i + 38;
      else if (i >= 29 && i <= 40) v = i + 47;
      else if (i >= 44 && i <= 54) v = i + 56;
      else if (i >= 71 && i <= 74) v = i - 3;
      else if (i >= 75 && i <= 77) v = i + 16;
      else if (i >= 79 && i <= 81) v = i + 33;
      else begin
         case (i)
            0: v = 127;  14: v = 43;  28: v = 89;  41: v = 42;  42: v = 99;
            43: v = 88;  55: v = 47;  56: v = 19;  57: v = 121; 58: v = 119;
            59: v = 5;   60: v = 6;   61: v = 8;   62: v = 10;  63: v = 12;
            64: v = 14;  65: v = 16;  66: v = 17;  67: v = 18;  68: v = 7;
            69: v = 98;  70: v = 23;  78: v = 125; 82: v = 94;  83: v = 50;
            86: v = 124; 87: v = 9;   88: v = 11;  96: v = 90;  98: v = 46;
            99: v = 22;  100: v = 13; 101: v = 111; 102: v = 52; 103: v = 20;
            104: v = 96; 105: v = 24; 106: v = 28; 107: v = 74; 108: v = 27;
            109: v = 123; 110: v = 44; 111: v = 66; 113: v = 45; 114: v = 2;
            115: v = 4;  116: v = 48; 119: v = 21; 125: v = 120; 126: v = 122;
            127: v = 67;
            default: v = 0;
         endcase
      end
      return 8'(v) | (s & 8'h80);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, compare outputs with the model, update model after the edge.
   task automatic step(bit kv, logic [7:0] ks, bit cv, logic [7:0] cb, bit re, string tag);
      logic [7:0] exp_head;
      bit room;
      @(negedge clk);
      key_valid = kv; key_scan = ks; cmd_valid = cv; cmd_byte = cb; rd_en = re;
      #1;
      exp_head = (mq.size() != 0) ? mq[0] : 8'h00;
      check(rd_avail == (mq.size() != 0), {tag, " avail"}, rd_avail, mq.size() != 0);
      check(rd_data == exp_head, {tag, " data"}, rd_data, exp_head);
      room = (mq.size() < 256);
      @(posedge clk);
      if (cv && (cb == 8'h01 || cb == 8'h07 || cb == 8'h0F)) begin
         mq.delete();
         if (cb == 8'h01) begin mq.push_back(8'hFF); mq.push_back(8'h04); end
         else begin mq.push_back(8'hFE); mq.push_back(8'h13); end
         if (kv) mq.push_back(ref_code(ks));
      end else begin
         if (re && mq.size() != 0) void'(mq.pop_front());
         if (kv && room) mq.push_back(ref_code(ks));
      end
   endtask

   task automatic idle(string tag);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
   endtask

   task automatic expect_head(logic [7:0] exp, bit av, string tag);
      @(negedge clk);
      key_valid = 0; cmd_valid = 0; rd_en = 0;
      #1;
      check(rd_avail == av, {tag, " avail"}, rd_avail, av);
      check(rd_data == exp, {tag, " head"}, rd_data, exp);
   endtask

   task automatic pop_expect(logic [7:0] exp, string tag);
      expect_head(exp, 1'b1, tag);
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9: reset state
      expect_head(8'h00, 1'b0, "R9 reset");

      // R1, R11: release bit pass-through, immediate head visibility
      step(1'b1, 8'h01, 1'b0, 8'h00, 1'b0, "R1");
      expect_head(8'h1D, 1'b1, "R11 head after push");
      step(1'b1, 8'h81, 1'b0, 8'h00, 1'b0, "R1");
      step(1'b1, 8'h0E, 1'b0, 8'h00, 1'b0, "R1");
      step(1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, "R1");
      pop_expect(8'h1D, "R1 idx1");
      pop_expect(8'h9D, "R1 release");
      pop_expect(8'h2B, "R1 idx14");
      pop_expect(8'hC3, "R1 idx127 release");
      // R2: unassigned entries
      step(1'b1, 8'h54, 1'b0, 8'h00, 1'b0, "R2");
      step(1'b1, 8'hFC, 1'b0, 8'h00, 1'b0, "R2");
      pop_expect(8'h00, "R2 idx84");
      pop_expect(8'h80, "R2 idx124 release");
      // R8: read while empty
      step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R8 empty pop");
      expect_head(8'h00, 1'b0, "R8 empty");

      // R3: reset command flushes queued keys
      step(1'b1, 8'h10, 1'b0, 8'h00, 1'b0, "R3");
      step(1'b1, 8'h11, 1'b0, 8'h00, 1'b0, "R3");
      step(1'b0, 8'h00, 1'b1, 8'h01, 1'b0, "R3");
      pop_expect(8'hFF, "R3 first");
      pop_expect(8'h04, "R3 second");
      expect_head(8'h00, 1'b0, "R3 only two");
      // R4: both layout queries
      step(1'b1, 8'h20, 1'b0, 8'h00, 1'b0, "R4");
      step(1'b0, 8'h00, 1'b1, 8'h07, 1'b0, "R4");
      pop_expect(8'hFE, "R4 cmd07 first");
      pop_expect(8'h13, "R4 cmd07 second");
      expect_head(8'h00, 1'b0, "R4 cmd07 only two");
      step(1'b0, 8'h00, 1'b1, 8'h0F, 1'b0, "R4");
      pop_expect(8'hFE, "R4 cmd0F first");
      pop_expect(8'h13, "R4 cmd0F second");
      // R5: other commands ignored
      step(1'b1, 8'h02, 1'b0, 8'h00, 1'b0, "R5");
      step(1'b0, 8'h00, 1'b1, 8'h02, 1'b0, "R5");
      step(1'b0, 8'h00, 1'b1, 8'h81, 1'b0, "R5");
      step(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, "R5");
      pop_expect(8'h1E, "R5 key kept");
      expect_head(8'h00, 1'b0, "R5 nothing added");
      // R6: command and key in the same cycle
      step(1'b1, 8'h03, 1'b1, 8'h01, 1'b0, "R6");
      pop_expect(8'hFF, "R6 answer first");
      pop_expect(8'h04, "R6 answer second");
      pop_expect(8'h1F, "R6 key last");

      // R7: fill beyond capacity, then drain
      for (int i = 0; i < 260; i++)
         step(1'b1, 8'(i), 1'b0, 8'h00, 1'b0, "R7 fill");
      step(1'b1, 8'h05, 1'b0, 8'h00, 1'b1, "R7 full push with pop");
      for (int i = 0; i < 256; i++)
         step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R7 drain");
      expect_head(8'h00, 1'b0, "R7 drained");

      // Random phase: R1 R5 R8 R10
      for (int n = 0; n < 6000; n++) begin
         bit kv, cv, re;
         logic [7:0] cb;
         int sel;
         kv = ($urandom_range(99) < ((n < 3000) ? 75 : 40));
         re = ($urandom_range(99) < ((n < 3000) ? 30 : 60));
         cv = ($urandom_range(99) < 3);
         sel = $urandom_range(3);
         cb = (sel == 0) ? 8'h01 : (sel == 1) ? 8'h07 : (sel == 2) ? 8'h0F : 8'($urandom);
         step(kv, 8'($urandom), cv, cb, re, "R10 random");
      end
      idle("R11 final");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule